// File: doc/BRIEF.md
# Per-Pin Change-Interrupt Controller

This block watches a 16-bit input port, organised as two 8-bit halves (port A in bits 7:0, port B in bits 15:8), and raises one interrupt per half. Each pin is gated by an enable bit. A mode bit chooses what the pin is compared against: either a programmable default level, or the level the pin had on the previous clock. The pin inputs arrive asynchronous to `clk` and pass through a two-flop synchronizer before any compare.

When an enabled pin mismatches, the half records which pins caused it in a flag vector and takes a snapshot of its port value in a capture register. Each half runs a two-state machine. In state ARMED the previous-value reference follows the port every clock. The ARMED to PENDING transition happens on any enabled mismatch. In state PENDING the flags, the snapshot and the reference are frozen. The PENDING to ARMED transition happens when the host reads that half's capture register or port register. Those reads are signalled to the block as one-cycle strobes.

The two interrupt lines can each serve their own half, or both can carry the OR of both halves. Their active level can be set by configuration.

Top module: `ioc_ctrl`

## Requirements
- R1: A pin whose enable bit is 0 never sets its flag and never starts an interrupt, whatever its level does.
- R2: With its mode bit at 1, an enabled pin raises an interrupt while its synchronized level differs from its default bit. If it still differs after a clear, it raises the interrupt again one clock later.
- R3: With its mode bit at 0, an enabled pin raises an interrupt when its level differs from the reference. The reference becomes the pin level at the interrupt. A change made while the interrupt is pending raises a fresh interrupt one clock after the clear. A pin that stays steady after a clear raises nothing. Several pins changing together all set their flags in one interrupt.
- R4: On an interrupt, each flag bit of that half is 1 exactly for the enabled pins that mismatched. The capture bits of that half take the synchronized port value.
- R5: While a half is PENDING, its flags and capture bits do not change, whatever the pins do.
- R6: A one-cycle strobe on `cap_rd_i[n]` or `port_rd_i[n]` moves half n (0 = A, 1 = B) to ARMED and zeroes its flags on the next edge. The capture bits keep their value. The other half is not affected.
- R7: With `mirror_i` at 0, `int_a_o` follows only port A and `int_b_o` follows only port B. With `mirror_i` at 1, both outputs show the OR of the two halves.
- R8: With `odr_i` at 0, `intpol_i` selects the active level: 1 means active-high and 0 means active-low. With `odr_i` at 1 both outputs are active-low, whatever `intpol_i` is. The outputs respond to these bits without a clock delay.
- R9: After reset all flags and capture bits are 0, both halves are ARMED and both interrupt outputs are at their inactive level.
- R10: A pin change first shows in the flags on the third rising edge after it is applied, because two synchronizer stages and one state register lie on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Polarity-corrected pin levels, asynchronous |
| en_i | input | 16 | Per-pin interrupt enable |
| dflt_i | input | 16 | Per-pin default level |
| cmpdef_i | input | 16 | Per-pin mode: 1 compares with the default, 0 compares with the previous value |
| cap_rd_i | input | 2 | Capture-register read strobe per half |
| port_rd_i | input | 2 | Port-register read strobe per half |
| mirror_i | input | 1 | OR both halves onto both interrupt outputs |
| intpol_i | input | 1 | 1 = active-high interrupt outputs |
| odr_i | input | 1 | Forces active-low (open-drain style) outputs |
| flag_o | output | 16 | Pins that caused the pending interrupt |
| cap_o | output | 16 | Port snapshot taken at the interrupt |
| int_a_o | output | 1 | Interrupt line A |
| int_b_o | output | 1 | Interrupt line B |

## Verification
The assertions assume that read strobes last one clock and that enable bits are only sampled at the edge where an interrupt is taken. The bench changes configuration and pins only on falling edges, at least three clocks apart. The enable vector stays fixed throughout the run, and strobes are single-cycle pulses. Each pin pattern is held until the expected flag and capture values have been compared, so no result depends on a synchronizer race.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_PEND  = 1'b1
    } ioc_state_e;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/ioc_port.sv
module ioc_port
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] dflt_i,
    input  logic [W-1:0] cmpdef_i,
    input  logic         clr_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] cap_o,
    output logic         pend_o
);
    ioc_state_e   state_q, state_d;
    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;
    logic [W-1:0] cap_q;
    logic [W-1:0] hit;

    // per-pin mismatch against the selected reference
    assign hit = en_i & ((cmpdef_i & (pin_i ^ dflt_i)) |
                         (~cmpdef_i & (pin_i ^ prev_q)));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (|hit) state_d = ST_PEND;
            ST_PEND:  if (clr_i) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
            cap_q  <= '0;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    prev_q <= pin_i;
                    if (|hit) begin
                        flag_q <= hit;
                        cap_q  <= pin_i;
                    end
                end
                ST_PEND: begin
                    if (clr_i) flag_q <= '0;
                end
                default: flag_q <= '0;
            endcase
        end
    end

    assign flag_o = flag_q;
    assign cap_o  = cap_q;
    assign pend_o = (state_q == ST_PEND);

    p_flag_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> ((flag_q & ~$past(en_i)) == '0));
    p_flag_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> (flag_q != '0));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> (pend_o && $stable(flag_q) && $stable(cap_q)));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && clr_i) |=> (!pend_o && flag_q == '0 && $stable(cap_q)));
endmodule

// File: rtl/ioc_irq_drive.sv
module ioc_irq_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_a_i,
    input  logic pend_b_i,
    input  logic mirror_i,
    input  logic intpol_i,
    input  logic odr_i,
    output logic int_a_o,
    output logic int_b_o
);
    logic req_a, req_b, act_high;

    assign req_a    = pend_a_i | (mirror_i & pend_b_i);
    assign req_b    = pend_b_i | (mirror_i & pend_a_i);
    assign act_high = intpol_i & ~odr_i;
    assign int_a_o  = act_high ? req_a : ~req_a;
    assign int_b_o  = act_high ? req_b : ~req_b;

    p_mirror_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_i |-> (int_a_o == int_b_o));
endmodule

// File: rtl/ioc_ctrl.sv
module ioc_ctrl #(
    parameter int PORT_W = 8,
    localparam int PIN_W = 2 * PORT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pin_i,
    input  logic [PIN_W-1:0] en_i,
    input  logic [PIN_W-1:0] dflt_i,
    input  logic [PIN_W-1:0] cmpdef_i,
    input  logic [1:0]       cap_rd_i,
    input  logic [1:0]       port_rd_i,
    input  logic             mirror_i,
    input  logic             intpol_i,
    input  logic             odr_i,
    output logic [PIN_W-1:0] flag_o,
    output logic [PIN_W-1:0] cap_o,
    output logic             int_a_o,
    output logic             int_b_o
);
    logic [PIN_W-1:0] pin_s;
    logic [1:0]       pend;

    ioc_sync #(.W(PIN_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
    );

    for (genvar gp = 0; gp < 2; gp++) begin : g_half
        ioc_port #(.W(PORT_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_s[gp*PORT_W +: PORT_W]),
            .en_i     (en_i[gp*PORT_W +: PORT_W]),
            .dflt_i   (dflt_i[gp*PORT_W +: PORT_W]),
            .cmpdef_i (cmpdef_i[gp*PORT_W +: PORT_W]),
            .clr_i    (cap_rd_i[gp] | port_rd_i[gp]),
            .flag_o   (flag_o[gp*PORT_W +: PORT_W]),
            .cap_o    (cap_o[gp*PORT_W +: PORT_W]),
            .pend_o   (pend[gp])
        );
    end

    ioc_irq_drive u_irq (
        .clk(clk), .rst_n(rst_n),
        .pend_a_i(pend[0]), .pend_b_i(pend[1]),
        .mirror_i(mirror_i), .intpol_i(intpol_i), .odr_i(odr_i),
        .int_a_o(int_a_o), .int_b_o(int_b_o)
    );
endmodule

// File: tb/ioc_ctrl_bench.sv
`timescale 1ns/1ps
module ioc_ctrl_bench;
    typedef struct {
        string       req;
        logic [15:0] flag;
        logic [15:0] cap;
        logic        ia;
        logic        ib;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] pins = '0, en = 16'hFDFF, dflt = '0, cmpdef = '0;
    logic [1:0]  cap_rd = '0, port_rd = '0;
    logic        mirror = 1'b0, intpol = 1'b0, odr = 1'b0;
    logic [15:0] flag_o, cap_o;
    logic        int_a_o, int_b_o;
    int checks = 0, errors = 0;
    bit done = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ioc_ctrl u_ioc_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .en_i(en), .dflt_i(dflt),
        .cmpdef_i(cmpdef), .cap_rd_i(cap_rd), .port_rd_i(port_rd),
        .mirror_i(mirror), .intpol_i(intpol), .odr_i(odr),
        .flag_o(flag_o), .cap_o(cap_o), .int_a_o(int_a_o), .int_b_o(int_b_o)
    );

    task automatic expect_now(input string req, input logic [15:0] f,
                              input logic [15:0] c, input logic a, input logic b);
        exp_t e;
        #1;
        e.req = req; e.flag = f; e.cap = c; e.ia = a; e.ib = b;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cap(input int h);
        cap_rd[h] = 1'b1; @(negedge clk); cap_rd[h] = 1'b0;
    endtask

    task automatic pulse_port(input int h);
        port_rd[h] = 1'b1; @(negedge clk); port_rd[h] = 1'b0;
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            exp_t e;
            wait (q.size() != 0);
            e = q.pop_front();
            checks++;
            if (flag_o !== e.flag || cap_o !== e.cap ||
                int_a_o !== e.ia || int_b_o !== e.ib) begin
                errors++;
                $display("FAIL %s: flag=%h cap=%h ia=%b ib=%b expected flag=%h cap=%h ia=%b ib=%b",
                         e.req, flag_o, cap_o, int_a_o, int_b_o, e.flag, e.cap, e.ia, e.ib);
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        settle(4);
        rst_n = 1'b1;
        settle(3);
        expect_now("R9 reset", 16'h0000, 16'h0000, 1'b1, 1'b1);

        pins = 16'h0008;
        settle(2);
        expect_now("R10 not before third edge", 16'h0000, 16'h0000, 1'b1, 1'b1);
        settle(1);
        expect_now("R3 R4 R10 prev-mode change", 16'h0008, 16'h0008, 1'b0, 1'b1);

        pins = 16'h0028;
        settle(3);
        expect_now("R5 hold while pending", 16'h0008, 16'h0008, 1'b0, 1'b1);

        pulse_cap(0);
        expect_now("R6 capture read clears A", 16'h0000, 16'h0008, 1'b1, 1'b1);
        settle(1);
        expect_now("R3 change during pending refires", 16'h0020, 16'h0028, 1'b0, 1'b1);

        pulse_port(0);
        expect_now("R6 port read clears A", 16'h0000, 16'h0028, 1'b1, 1'b1);
        settle(3);
        expect_now("R3 steady pin no refire", 16'h0000, 16'h0028, 1'b1, 1'b1);

        pins = 16'h0228;
        settle(3);
        expect_now("R1 disabled pin ignored", 16'h0000, 16'h0028, 1'b1, 1'b1);

        pins = 16'h0028; cmpdef = 16'hFF00;
        settle(3);
        pins = 16'h0428;
        settle(3);
        expect_now("R2 default mismatch B", 16'h0400, 16'h0428, 1'b1, 1'b0);

        pulse_cap(1);
        expect_now("R6 capture read clears B only", 16'h0000, 16'h0428, 1'b1, 1'b1);
        settle(1);
        expect_now("R2 still differs refires", 16'h0400, 16'h0428, 1'b1, 1'b0);

        dflt = 16'h0400;
        pulse_port(1);
        settle(3);
        expect_now("R2 matches default stays clear", 16'h0000, 16'h0428, 1'b1, 1'b1);

        mirror = 1'b1; pins = 16'h042A;
        settle(3);
        expect_now("R7 mirror A onto both", 16'h0002, 16'h042A, 1'b0, 1'b0);

        intpol = 1'b1;
        expect_now("R8 active-high", 16'h0002, 16'h042A, 1'b1, 1'b1);
        odr = 1'b1;
        expect_now("R8 odr forces active-low", 16'h0002, 16'h042A, 1'b0, 1'b0);

        settle(1);
        pulse_port(0);
        expect_now("R6 R7 cleared both idle", 16'h0000, 16'h042A, 1'b1, 1'b1);

        odr = 1'b0; mirror = 1'b0; pins = 16'h04EA;
        settle(3);
        expect_now("R3 R4 two pins one interrupt", 16'h00C0, 16'h04EA, 1'b1, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule